// File: doc/BRIEF.md
# Word/Byte Memory Port Controller

This block sits between a microcoded datapath and a unified RAM. It holds the four memory-facing registers: a word address register, a word data register, a program counter and a one-byte instruction register. It turns the read, write and fetch bits of each control word into RAM strobes. Data traffic goes through a 32-bit word port addressed by the word address register. Instruction fetches go through a separate byte port addressed by the program counter. Because the two ports are separate, a fetch can run in the same cycle as a data read or a data write.

Each strobe is registered. A request raised in cycle N appears on the RAM port in cycle N+1 and uses the register values as they stand after the edge that ends cycle N. The RAM answers combinationally in that same cycle. The returned value is captured at the end of cycle N+1, so software can use it from cycle N+2 onward.

The block also drives one word onto the datapath's B bus. It can show the data register, the program counter, or the instruction byte widened to a full word with either zero fill or sign fill.

Top module: `mport_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, all RAM strobes and `rw_clash` are low, and every register reads back as zero through `b_val`.
- R2: When `mem_rd` is high and `mem_wr` is low in cycle N, `ram_drd` is high in cycle N+1 and `ram_dwr` is low. In that cycle `ram_daddr` equals the word address register shifted left by two, using the register value after the edge that ends cycle N.
- R3: Data returned on `ram_rdata` in cycle N+1 is held in the data register from cycle N+2 onward. During cycle N+1, selecting the data register still shows its old value.
- R4: When `mem_wr` is high in cycle N, `ram_dwr` is high in cycle N+1. In that cycle `ram_daddr` is the shifted word address and `ram_wdata` is the data register value after the edge that ends cycle N.
- R5: When `mem_fetch` is high in cycle N, `ram_fetch` is high in cycle N+1 and `ram_faddr` carries the program counter as a byte address. The byte on `ram_fdata` is held in the instruction register from cycle N+2 onward.
- R6: A fetch and a data read, both raised in the same cycle, are carried out independently on the two ports, and both results are captured.
- R7: When `mem_rd` and `mem_wr` are both high in cycle N, only the write is issued in cycle N+1 (`ram_drd` low), `rw_clash` is high in cycle N+1, and the data register is not loaded from RAM afterwards.
- R8: With `b_src` = 2, `b_val` is the instruction byte zero-extended to 32 bits.
- R9: With `b_src` = 3, `b_val` is the instruction byte sign-extended from bit 7.
- R10: With `b_src` = 0, `b_val` is the data register, and with `b_src` = 1 it is the program counter. For both codes and for codes 2 and 3, `b_hit` is high. For any other code, `b_hit` is low and `b_val` is zero.
- R11: If read data returns at the same edge at which `ld_mdr` loads the data register from `c_bus`, the returned data wins.
- R12: `ld_mar`, `ld_mdr` and `ld_pc` each load their register from `c_bus` at the clock edge, and leave it unchanged when low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| c_bus | input | 32 | Result bus from the datapath |
| ld_mar | input | 1 | Load word address register from `c_bus` |
| ld_mdr | input | 1 | Load data register from `c_bus` |
| ld_pc | input | 1 | Load program counter from `c_bus` |
| mem_rd | input | 1 | Control word: start a data read |
| mem_wr | input | 1 | Control word: start a data write |
| mem_fetch | input | 1 | Control word: start a byte fetch |
| b_src | input | 4 | B bus source code |
| b_val | output | 32 | Value driven toward the B bus |
| b_hit | output | 1 | `b_src` names a register of this block |
| ram_daddr | output | 32 | Data port byte address |
| ram_drd | output | 1 | Data port read strobe |
| ram_dwr | output | 1 | Data port write strobe |
| ram_wdata | output | 32 | Data port write word |
| ram_rdata | input | 32 | Data port read word |
| ram_faddr | output | 32 | Fetch port byte address |
| ram_fetch | output | 1 | Fetch port strobe |
| ram_fdata | input | 8 | Fetch port byte |
| rw_clash | output | 1 | Read and write were requested together |

## Verification
The capture checks assume that the RAM returns read data combinationally in the cycle in which the strobe is high. The bench's memory model does exactly that: it decodes `ram_daddr` and `ram_faddr` through continuous logic and commits writes at the closing edge of the write-strobe cycle. The request checks read the control bits one edge back, so they depend on inputs changing only between edges. The bench therefore drives every input shortly after a rising edge. The combined read-and-write case is outside legal use, and the bench raises it in one deliberate test only, to see that it is flagged and resolved.

// File: rtl/mport_pkg.sv
package mport_pkg;
   localparam int BSRC_W = 4;

   localparam logic [BSRC_W-1:0] SRC_MDR  = 4'd0;
   localparam logic [BSRC_W-1:0] SRC_PC   = 4'd1;
   localparam logic [BSRC_W-1:0] SRC_MBRU = 4'd2;
   localparam logic [BSRC_W-1:0] SRC_MBRS = 4'd3;

   typedef struct packed {
      logic rd;
      logic wr;
      logic clash;
   } dreq_t;
endpackage

// File: rtl/mport_dpath.sv
module mport_dpath
   import mport_pkg::*;
#(
   parameter int W          = 32,
   parameter int BYTE_W     = 8,
   parameter bit WORD_INDEX = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] c_bus,
   input  logic         ld_mar,
   input  logic         ld_mdr,
   input  logic         mem_rd,
   input  logic         mem_wr,
   input  logic [W-1:0] ram_rdata,
   output logic [W-1:0] ram_daddr,
   output logic         ram_drd,
   output logic         ram_dwr,
   output logic [W-1:0] ram_wdata,
   output logic         rw_clash,
   output logic [W-1:0] mdr_q
);
   localparam int LANES = W / BYTE_W;
   localparam int SHIFT = $clog2(LANES);

   logic [W-1:0] mar_q, mar_d, mdr_d, addr_d;
   dreq_t        req;

   always_comb begin
      req.wr    = mem_wr;
      req.rd    = mem_rd & ~mem_wr;
      req.clash = mem_rd & mem_wr;
   end

   assign mar_d = ld_mar ? c_bus : mar_q;

   always_comb begin
      if (ram_drd)
         mdr_d = ram_rdata;
      else if (ld_mdr)
         mdr_d = c_bus;
      else
         mdr_d = mdr_q;
   end

   generate
      if (WORD_INDEX) begin : g_word_idx
         assign addr_d = mar_d << SHIFT;
      end else begin : g_byte_idx
         assign addr_d = mar_d;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mar_q     <= '0;
         mdr_q     <= '0;
         ram_drd   <= 1'b0;
         ram_dwr   <= 1'b0;
         rw_clash  <= 1'b0;
         ram_daddr <= '0;
         ram_wdata <= '0;
      end else begin
         mar_q    <= mar_d;
         mdr_q    <= mdr_d;
         ram_drd  <= req.rd;
         ram_dwr  <= req.wr;
         rw_clash <= req.clash;
         if (req.rd || req.wr)
            ram_daddr <= addr_d;
         if (req.wr)
            ram_wdata <= mdr_d;
      end
   end
endmodule

// File: rtl/mport_fpath.sv
module mport_fpath #(
   parameter int W      = 32,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [W-1:0]      c_bus,
   input  logic              ld_pc,
   input  logic              mem_fetch,
   input  logic [BYTE_W-1:0] ram_fdata,
   output logic [W-1:0]      ram_faddr,
   output logic              ram_fetch,
   output logic [W-1:0]      pc_q,
   output logic [BYTE_W-1:0] mbr_q
);
   logic [W-1:0] pc_d;

   assign pc_d = ld_pc ? c_bus : pc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q      <= '0;
         mbr_q     <= '0;
         ram_fetch <= 1'b0;
         ram_faddr <= '0;
      end else begin
         pc_q      <= pc_d;
         ram_fetch <= mem_fetch;
         if (mem_fetch)
            ram_faddr <= pc_d;
         if (ram_fetch)
            mbr_q <= ram_fdata;
      end
   end
endmodule

// File: rtl/mport_bview.sv
module mport_bview
   import mport_pkg::*;
#(
   parameter int W      = 32,
   parameter int BYTE_W = 8
) (
   input  logic [BSRC_W-1:0] b_src,
   input  logic [W-1:0]      mdr_q,
   input  logic [W-1:0]      pc_q,
   input  logic [BYTE_W-1:0] mbr_q,
   output logic [W-1:0]      b_val,
   output logic              b_hit
);
   localparam int PAD = W - BYTE_W;

   logic [W-1:0] mbr_zx, mbr_sx;

   assign mbr_zx = {{PAD{1'b0}}, mbr_q};
   assign mbr_sx = {{PAD{mbr_q[BYTE_W-1]}}, mbr_q};

   always_comb begin
      b_hit = 1'b1;
      case (b_src)
         SRC_MDR:  b_val = mdr_q;
         SRC_PC:   b_val = pc_q;
         SRC_MBRU: b_val = mbr_zx;
         SRC_MBRS: b_val = mbr_sx;
         default: begin
            b_val = '0;
            b_hit = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/mport_ctrl.sv
module mport_ctrl
   import mport_pkg::*;
#(
   parameter int W          = 32,
   parameter int BYTE_W     = 8,
   parameter bit WORD_INDEX = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [W-1:0]      c_bus,
   input  logic              ld_mar,
   input  logic              ld_mdr,
   input  logic              ld_pc,
   input  logic              mem_rd,
   input  logic              mem_wr,
   input  logic              mem_fetch,
   input  logic [BSRC_W-1:0] b_src,
   output logic [W-1:0]      b_val,
   output logic              b_hit,
   output logic [W-1:0]      ram_daddr,
   output logic              ram_drd,
   output logic              ram_dwr,
   output logic [W-1:0]      ram_wdata,
   input  logic [W-1:0]      ram_rdata,
   output logic [W-1:0]      ram_faddr,
   output logic              ram_fetch,
   input  logic [BYTE_W-1:0] ram_fdata,
   output logic              rw_clash
);
   generate
      if (BYTE_W < 1 || W <= BYTE_W || (W % BYTE_W) != 0) begin : g_bad_width
         $error("mport_ctrl: W must be a larger multiple of BYTE_W");
      end
      if (((W / BYTE_W) & ((W / BYTE_W) - 1)) != 0) begin : g_bad_lanes
         $error("mport_ctrl: lane count must be a power of two");
      end
   endgenerate

   logic [W-1:0]      mdr_q;
   logic [W-1:0]      pc_q;
   logic [BYTE_W-1:0] mbr_q;

   mport_dpath #(.W(W), .BYTE_W(BYTE_W), .WORD_INDEX(WORD_INDEX)) i_dpath (
      .clk       (clk),
      .rst_n     (rst_n),
      .c_bus     (c_bus),
      .ld_mar    (ld_mar),
      .ld_mdr    (ld_mdr),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .ram_rdata (ram_rdata),
      .ram_daddr (ram_daddr),
      .ram_drd   (ram_drd),
      .ram_dwr   (ram_dwr),
      .ram_wdata (ram_wdata),
      .rw_clash  (rw_clash),
      .mdr_q     (mdr_q)
   );

   mport_fpath #(.W(W), .BYTE_W(BYTE_W)) i_fpath (
      .clk       (clk),
      .rst_n     (rst_n),
      .c_bus     (c_bus),
      .ld_pc     (ld_pc),
      .mem_fetch (mem_fetch),
      .ram_fdata (ram_fdata),
      .ram_faddr (ram_faddr),
      .ram_fetch (ram_fetch),
      .pc_q      (pc_q),
      .mbr_q     (mbr_q)
   );

   mport_bview #(.W(W), .BYTE_W(BYTE_W)) i_bview (
      .b_src (b_src),
      .mdr_q (mdr_q),
      .pc_q  (pc_q),
      .mbr_q (mbr_q),
      .b_val (b_val),
      .b_hit (b_hit)
   );
endmodule

// File: rtl/mport_chk.sv
module mport_chk
   import mport_pkg::*;
#(
   parameter int W      = 32,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              mem_fetch,
   input logic [BSRC_W-1:0] b_src,
   input logic [W-1:0]      b_val,
   input logic              ram_drd,
   input logic              ram_dwr,
   input logic [W-1:0]      ram_rdata,
   input logic              ram_fetch,
   input logic [BYTE_W-1:0] ram_fdata,
   input logic              rw_clash,
   input logic [W-1:0]      mdr_q,
   input logic [BYTE_W-1:0] mbr_q
);
   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R7
   no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_drd && ram_dwr));

   // R2
   rd_issue_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      $past(mem_rd && !mem_wr) |-> ram_drd);

   // R4
   wr_issue_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      $past(mem_wr) |-> ram_dwr);

   // R7
   clash_flag_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      $past(mem_rd && mem_wr) |-> (rw_clash && !ram_drd));

   // R3
   mdr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_drd |=> (mdr_q == $past(ram_rdata)));

   // R5
   mbr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_fetch |=> (mbr_q == $past(ram_fdata)));

   // R5
   fetch_issue_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      $past(mem_fetch) |-> ram_fetch);

   // R9
   mbr_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b_src == SRC_MBRS) |-> (b_val[W-1:BYTE_W] == {(W-BYTE_W){mbr_q[BYTE_W-1]}}));

   // R8
   mbr_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b_src == SRC_MBRU) |-> (b_val[W-1:BYTE_W] == '0));
endmodule

bind mport_ctrl mport_chk #(.W(W), .BYTE_W(BYTE_W)) i_mport_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .mem_fetch (mem_fetch),
   .b_src     (b_src),
   .b_val     (b_val),
   .ram_drd   (ram_drd),
   .ram_dwr   (ram_dwr),
   .ram_rdata (ram_rdata),
   .ram_fetch (ram_fetch),
   .ram_fdata (ram_fdata),
   .rw_clash  (rw_clash),
   .mdr_q     (mdr_q),
   .mbr_q     (mbr_q)
);

// File: tb/test_mport_ctrl.sv
`timescale 1ns/1ps
module test_mport_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] c_bus = '0;
   logic        ld_mar = 1'b0, ld_mdr = 1'b0, ld_pc = 1'b0;
   logic        mem_rd = 1'b0, mem_wr = 1'b0, mem_fetch = 1'b0;
   logic [3:0]  b_src = 4'd0;
   logic [31:0] b_val;
   logic        b_hit;
   logic [31:0] ram_daddr, ram_wdata, ram_rdata, ram_faddr;
   logic        ram_drd, ram_dwr, ram_fetch, rw_clash;
   logic [7:0]  ram_fdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] mem [256];

   always #2 clk = ~clk;

   mport_ctrl i_mport_ctrl (
      .clk(clk), .rst_n(rst_n), .c_bus(c_bus),
      .ld_mar(ld_mar), .ld_mdr(ld_mdr), .ld_pc(ld_pc),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_fetch(mem_fetch),
      .b_src(b_src), .b_val(b_val), .b_hit(b_hit),
      .ram_daddr(ram_daddr), .ram_drd(ram_drd), .ram_dwr(ram_dwr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
      .ram_faddr(ram_faddr), .ram_fetch(ram_fetch), .ram_fdata(ram_fdata),
      .rw_clash(rw_clash)
   );

   function automatic logic [31:0] word_at(input logic [7:0] a);
      return {mem[8'(a + 8'd3)], mem[8'(a + 8'd2)], mem[8'(a + 8'd1)], mem[a]};
   endfunction

   always_comb ram_rdata = word_at(ram_daddr[7:0]);
   always_comb ram_fdata = mem[ram_faddr[7:0]];

   always @(posedge clk) begin
      if (ram_dwr) begin
         for (int k = 0; k < 4; k++)
            mem[8'(ram_daddr[7:0] + 8'(k))] <= ram_wdata[8*k +: 8];
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      ld_mar = 0; ld_mdr = 0; ld_pc = 0;
      mem_rd = 0; mem_wr = 0; mem_fetch = 0;
   endtask

   task automatic t_reset();
      chk("R1 drd in reset", {31'd0, ram_drd}, 32'd0);
      chk("R1 dwr in reset", {31'd0, ram_dwr}, 32'd0);
      rst_n = 1'b1;
      step();
      chk("R1 fetch strobe", {31'd0, ram_fetch}, 32'd0);
      chk("R1 clash flag", {31'd0, rw_clash}, 32'd0);
      b_src = 4'd0; #0.1; chk("R1 mdr zero", b_val, 32'd0);
      b_src = 4'd1; #0.1; chk("R1 pc zero", b_val, 32'd0);
      b_src = 4'd2; #0.1; chk("R1 mbr zero", b_val, 32'd0);
   endtask

   task automatic t_read();
      logic [31:0] exp_w;
      exp_w = word_at(8'd20);
      b_src = 4'd0;
      c_bus = 32'd5; ld_mar = 1; mem_rd = 1;
      step();
      idle();
      chk("R2 read strobe", {31'd0, ram_drd}, 32'd1);
      chk("R2 no write strobe", {31'd0, ram_dwr}, 32'd0);
      chk("R2 read address", ram_daddr, 32'd20);
      #0.1;
      chk("R3 old mdr during N+1", b_val, 32'd0);
      step();
      chk("R3 mdr holds read word", b_val, exp_w);
   endtask

   task automatic t_write();
      c_bus = 32'd9; ld_mar = 1; step(); idle();
      c_bus = 32'hDEADBEEF; ld_mdr = 1; mem_wr = 1;
      step();
      idle();
      chk("R4 write strobe", {31'd0, ram_dwr}, 32'd1);
      chk("R4 write address", ram_daddr, 32'd36);
      chk("R4 write data", ram_wdata, 32'hDEADBEEF);
      c_bus = 32'd0; ld_mdr = 1;
      step();
      idle();
      b_src = 4'd0; #0.1;
      chk("R12 mdr loaded from c_bus", b_val, 32'd0);
      mem_rd = 1; step(); idle(); step();
      chk("R4 word stored in ram", b_val, 32'hDEADBEEF);
      step();
      chk("R12 mdr held without load", b_val, 32'hDEADBEEF);
   endtask

   task automatic t_overlap();
      logic [31:0] exp_w;
      exp_w = word_at(8'd12);
      c_bus = 32'h30; ld_pc = 1; step(); idle();
      c_bus = 32'd3; ld_mar = 1; mem_rd = 1; mem_fetch = 1;
      step();
      idle();
      chk("R6 fetch strobe with read", {31'd0, ram_fetch}, 32'd1);
      chk("R6 read strobe with fetch", {31'd0, ram_drd}, 32'd1);
      chk("R5 fetch address", ram_faddr, 32'h30);
      b_src = 4'd2; #0.1;
      chk("R5 old mbr during N+1", b_val, 32'd0);
      step();
      chk("R8 zero-extended mbr", b_val, 32'h0000009C);
      b_src = 4'd3; #0.1;
      chk("R9 sign-extended mbr", b_val, 32'hFFFFFF9C);
      b_src = 4'd0; #0.1;
      chk("R6 mdr after overlap", b_val, exp_w);
   endtask

   task automatic t_fetch_pos();
      c_bus = 32'h31; ld_pc = 1; mem_fetch = 1;
      step();
      idle();
      step();
      b_src = 4'd3; #0.1;
      chk("R9 positive byte sign-extended", b_val, 32'h00000041);
      b_src = 4'd2; #0.1;
      chk("R8 positive byte zero-extended", b_val, 32'h00000041);
      b_src = 4'd1; #0.1;
      chk("R10 pc view", b_val, 32'h31);
      chk("R10 hit for pc", {31'd0, b_hit}, 32'd1);
   endtask

   task automatic t_clash();
      logic [31:0] old_w;
      old_w = word_at(8'd56);
      chk("R7 precondition ram differs", {31'd0, old_w == 32'h12345678}, 32'd0);
      c_bus = 32'd14; ld_mar = 1; step(); idle();
      c_bus = 32'h12345678; ld_mdr = 1; mem_rd = 1; mem_wr = 1;
      step();
      idle();
      chk("R7 write issued", {31'd0, ram_dwr}, 32'd1);
      chk("R7 read suppressed", {31'd0, ram_drd}, 32'd0);
      chk("R7 clash flagged", {31'd0, rw_clash}, 32'd1);
      step();
      chk("R7 clash flag clears", {31'd0, rw_clash}, 32'd0);
      b_src = 4'd0; #0.1;
      chk("R7 mdr not reloaded", b_val, 32'h12345678);
   endtask

   task automatic t_ret_prio();
      logic [31:0] exp_w;
      exp_w = word_at(8'd8);
      c_bus = 32'd2; ld_mar = 1; mem_rd = 1;
      step();
      idle();
      c_bus = 32'hAAAA5555; ld_mdr = 1;
      step();
      idle();
      b_src = 4'd0; #0.1;
      chk("R11 returned data beats c_bus", b_val, exp_w);
   endtask

   task automatic t_other_codes();
      for (int c = 4; c < 16; c++) begin
         b_src = 4'(c); #0.1;
         chk("R10 unknown code value", b_val, 32'd0);
         chk("R10 unknown code hit", {31'd0, b_hit}, 32'd0);
      end
      b_src = 4'd0; #0.1;
      chk("R10 hit for mdr", {31'd0, b_hit}, 32'd1);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
      mem[8'h30] = 8'h9C;
      mem[8'h31] = 8'h41;
      #1;
      step();
      t_reset();
      t_read();
      t_write();
      t_overlap();
      t_fetch_pos();
      t_clash();
      t_ret_prio();
      t_other_codes();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule